// File: doc/BRIEF.md
# Register-Machine Instruction Execution Core

This block runs programs for a 32-bit word machine with eight general registers. It fetches one word at a time from the program array at the program counter and advances the counter. It then decodes one of fourteen operations and carries it out over several cycles. Register moves, addition, multiplication and the single logic operation (NAND) finish inside the core. Unsigned division runs on an iterative divider. Every array action goes to an external array manager: reading a word, writing a word, creating an array, releasing an array, and replacing the program array. Instruction fetches use the same request/acknowledge port. Console bytes enter and leave through valid/ready streams.

The core halts on the halt operation. It stops with its fault output raised on any of these: an undefined opcode, division by zero, output of a value above one byte, or a fault flag returned by the array manager. Both stop states last until reset.

Top module: `wmc_core`

## Requirements
- R1: After a synchronous active-low reset, all eight registers are zero, `halted` and `fault` are low, and the first request is a fetch (request opcode 0) from array id 0 at offset 0.
- R2: The opcode is word bits [31:28]. Standard operations take register A from bits [8:6], B from bits [5:3] and C from bits [2:0]. Opcode 13 takes its register from bits [27:25] and loads bits [24:0] into it, zero-extended.
- R3: Each fetch reads the offset given by the program counter. The counter grows by one when the fetched word arrives, before the operation takes effect, so programs run at consecutive offsets.
- R4: Opcode 0 copies B into A when C is nonzero. When C is zero, A keeps its old value.
- R5: Opcode 3 writes B+C and opcode 4 writes B*C into A, both modulo 2^32. Opcode 6 writes ~(B & C).
- R6: Opcode 5 writes the unsigned quotient B/C into A. If C is zero, the core raises `fault` and issues no further requests.
- R7: Array operations use these request opcodes: read=1 (id=B, offset=C, ack data into A), write=2 (id=A, offset=B, data=C), create=3 (size=C in the offset field, ack data into B), release=4 (id=C), program-load=5 (id=B, offset=C). After a program-load, fetching resumes at offset C.
- R8: An acknowledge that carries the fault flag raises `fault`, and the core writes no result.
- R9: Opcode 10 presents the low byte of C on the output stream and holds it until it is accepted. A C value above 255 raises `fault` instead.
- R10: Opcode 11 stalls until an input byte is valid, then loads it into C zero-extended. If the byte is flagged as end-of-input, C receives 32'hFFFF_FFFF.
- R11: Opcode 7 raises `halted`. After that the core makes no further array, output or input activity.
- R12: Opcodes 14 and 15 raise `fault` and stop the core.
- R13: An array-port request keeps its opcode, id, offset and data steady until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| am_req_valid | output | 1 | Array-port request pending |
| am_req_op | output | 3 | Request opcode (fetch, read, write, create, release, program-load) |
| am_req_id | output | 32 | Array identifier |
| am_req_off | output | 32 | Offset, or size for create |
| am_req_data | output | 32 | Write data |
| am_ack | input | 1 | Request completed this cycle |
| am_ack_data | input | 32 | Fetched word, read word or new id |
| am_ack_fault | input | 1 | Request failed |
| cout_valid | output | 1 | Output byte valid |
| cout_data | output | 8 | Output byte |
| cout_ready | input | 1 | Output byte accepted |
| cin_valid | input | 1 | Input byte valid |
| cin_data | input | 8 | Input byte |
| cin_eof | input | 1 | Input marks end of input |
| cin_ready | output | 1 | Core waiting for input |
| halted | output | 1 | Core stopped by halt |
| fault | output | 1 | Core stopped by a fault |

## Verification
The hardest situation to reach is a program-load. It swaps the program array under the running core, and execution must continue at a nonzero offset in the new array. The bench's array-manager model stages a replacement program in a data array and copies it into the program store when the load request arrives. The staged program starts with a halt word at offset 0, so a wrong resume offset ends the run without the expected write. The bench also logs fetch offsets to confirm where fetching resumed.

// File: rtl/wmc_pkg.sv
// Shared constants and types for the word-machine execution core.
// Assumes a 32-bit word, eight registers and a 4-bit opcode at the top.
package wmc_pkg;
    localparam int WORD_W  = 32;
    localparam int NREG    = 8;
    localparam int RIDX_W  = $clog2(NREG);
    localparam int OP_W    = 4;
    localparam int IMM_W   = WORD_W - OP_W - RIDX_W;
    localparam int BYTE_W  = 8;

    localparam logic [OP_W-1:0] OP_CMOV  = 4'd0;
    localparam logic [OP_W-1:0] OP_RD    = 4'd1;
    localparam logic [OP_W-1:0] OP_WR    = 4'd2;
    localparam logic [OP_W-1:0] OP_ADD   = 4'd3;
    localparam logic [OP_W-1:0] OP_MUL   = 4'd4;
    localparam logic [OP_W-1:0] OP_DIV   = 4'd5;
    localparam logic [OP_W-1:0] OP_NAND  = 4'd6;
    localparam logic [OP_W-1:0] OP_HALT  = 4'd7;
    localparam logic [OP_W-1:0] OP_NEW   = 4'd8;
    localparam logic [OP_W-1:0] OP_DROP  = 4'd9;
    localparam logic [OP_W-1:0] OP_OUT   = 4'd10;
    localparam logic [OP_W-1:0] OP_IN    = 4'd11;
    localparam logic [OP_W-1:0] OP_LOADP = 4'd12;
    localparam logic [OP_W-1:0] OP_IMM   = 4'd13;

    typedef enum logic [2:0] {
        AM_FETCH = 3'd0,
        AM_READ  = 3'd1,
        AM_WRITE = 3'd2,
        AM_ALLOC = 3'd3,
        AM_FREE  = 3'd4,
        AM_LOADP = 3'd5
    } am_op_e;

    typedef enum logic [2:0] {
        ST_FETCH, ST_EXEC, ST_ARRAY, ST_DIV, ST_OUT, ST_IN, ST_HALT, ST_FAULT
    } state_e;
endpackage

// File: rtl/wmc_regfile.sv
// General register file: NREG registers of W bits, three combinational
// read ports and one synchronous write port. All registers clear on reset.
module wmc_regfile #(
    parameter int W = 32,
    parameter int N = 8,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    input  logic [AW-1:0] ra_c,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    output logic [W-1:0]  rd_c
);
    logic [W-1:0] regs [N];

    for (genvar g = 0; g < N; g++) begin : g_reg
        // Holds one register; writes only when its index is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (we && waddr == AW'(g))
                regs[g] <= wdata;
        end
    end

    // Read ports.
    always_comb begin
        rd_a = regs[ra_a];
        rd_b = regs[ra_b];
        rd_c = regs[ra_c];
    end
endmodule

// File: rtl/wmc_alu.sv
// Single-cycle arithmetic for add, multiply and NAND, all modulo 2^W.
// Other opcodes produce zero; the core does not use the result for them.
module wmc_alu #(
    parameter int W = 32
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] y
);
    import wmc_pkg::*;

    // Operation select.
    always_comb begin
        case (op)
            OP_ADD:  y = b + c;
            OP_MUL:  y = b * c;
            OP_NAND: y = ~(b & c);
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/wmc_divider.sv
// Restoring shift-subtract unsigned divider, one quotient bit per cycle.
// A start while idle latches the operands. done pulses for one cycle W
// cycles later, with quo valid. Assumes the caller never starts it with a
// zero divisor.
module wmc_divider #(
    parameter int W = 32,
    localparam int CNT_W = $clog2(W + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quo
);
    logic [W-1:0]     rem_q, quo_q, num_q, den_q;
    logic [CNT_W-1:0] cnt;
    logic             run;
    logic [W:0]       rem_sh, diff;

    // Trial subtraction for the current step.
    always_comb begin
        rem_sh = {rem_q, quo_q[W-1]};
        diff   = rem_sh - {1'b0, den_q};
    end

    // Iteration control and partial-remainder update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run   <= 1'b0;
            done  <= 1'b0;
            cnt   <= '0;
            rem_q <= '0;
            quo_q <= '0;
            num_q <= '0;
            den_q <= '0;
        end else begin
            done <= 1'b0;
            if (start && !run) begin
                run   <= 1'b1;
                cnt   <= CNT_W'(W);
                rem_q <= '0;
                quo_q <= num;
                num_q <= num;
                den_q <= den;
            end else if (run) begin
                if (!diff[W]) begin
                    rem_q <= diff[W-1:0];
                    quo_q <= {quo_q[W-2:0], 1'b1};
                end else begin
                    rem_q <= rem_sh[W-1:0];
                    quo_q <= {quo_q[W-2:0], 1'b0};
                end
                cnt <= cnt - 1'b1;
                if (cnt == CNT_W'(1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign busy = run;
    assign quo  = quo_q;

    // R6: the finished quotient and remainder reconstruct the dividend.
    a_r6_div_exact: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((2*W)'(quo_q) * (2*W)'(den_q) + (2*W)'(rem_q) == (2*W)'(num_q))
                 && (rem_q < den_q));
    // R6: done appears only at the end of a run.
    a_r6_done_once: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !run);
endmodule

// File: rtl/wmc_core.sv
// Multi-cycle execution core: fetch through the array port, decode, then
// execute. Arithmetic runs locally, division runs on the iterative divider,
// array actions go to the external manager and console bytes use
// valid/ready streams. Halt and fault are sticky until reset. Assumes the
// manager raises am_ack for one cycle per accepted request.
module wmc_core
    import wmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    output logic              am_req_valid,
    output logic [2:0]        am_req_op,
    output logic [WORD_W-1:0] am_req_id,
    output logic [WORD_W-1:0] am_req_off,
    output logic [WORD_W-1:0] am_req_data,
    input  logic              am_ack,
    input  logic [WORD_W-1:0] am_ack_data,
    input  logic              am_ack_fault,
    output logic              cout_valid,
    output logic [BYTE_W-1:0] cout_data,
    input  logic              cout_ready,
    input  logic              cin_valid,
    input  logic [BYTE_W-1:0] cin_data,
    input  logic              cin_eof,
    output logic              cin_ready,
    output logic              halted,
    output logic              fault
);
    localparam int W = WORD_W;

    state_e             st;
    logic [W-1:0]       pc, ir;
    logic [OP_W-1:0]    op;
    logic [RIDX_W-1:0]  fa, fb, fc, fi;
    logic [IMM_W-1:0]   imm;
    logic [W-1:0]       va, vb, vc, alu_y, div_q;
    logic               we;
    logic [RIDX_W-1:0]  waddr;
    logic [W-1:0]       wdata;
    logic               div_start, div_busy, div_done;
    am_op_e             req_op;

    // Instruction field extraction.
    always_comb begin
        op  = ir[W-1 -: OP_W];
        fa  = ir[2*RIDX_W +: RIDX_W];
        fb  = ir[RIDX_W +: RIDX_W];
        fc  = ir[0 +: RIDX_W];
        fi  = ir[W-OP_W-1 -: RIDX_W];
        imm = ir[IMM_W-1:0];
    end

    wmc_regfile #(.W(W), .N(NREG)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
        .ra_a(fa), .ra_b(fb), .ra_c(fc), .rd_a(va), .rd_b(vb), .rd_c(vc)
    );

    wmc_alu #(.W(W)) u_alu (.op(op), .b(vb), .c(vc), .y(alu_y));

    assign div_start = (st == ST_EXEC) && (op == OP_DIV) && (vc != '0);

    wmc_divider #(.W(W)) u_div (
        .clk(clk), .rst_n(rst_n), .start(div_start), .num(vb), .den(vc),
        .busy(div_busy), .done(div_done), .quo(div_q)
    );

    // Register write-back source selection.
    always_comb begin
        we    = 1'b0;
        waddr = fa;
        wdata = alu_y;
        case (st)
            ST_EXEC: begin
                case (op)
                    OP_CMOV: begin
                        we    = (vc != '0);
                        wdata = vb;
                    end
                    OP_ADD, OP_MUL, OP_NAND: we = 1'b1;
                    OP_IMM: begin
                        we    = 1'b1;
                        waddr = fi;
                        wdata = W'(imm);
                    end
                    default: we = 1'b0;
                endcase
            end
            ST_ARRAY: begin
                if (am_ack && !am_ack_fault) begin
                    if (op == OP_RD) begin
                        we    = 1'b1;
                        wdata = am_ack_data;
                    end else if (op == OP_NEW) begin
                        we    = 1'b1;
                        waddr = fb;
                        wdata = am_ack_data;
                    end
                end
            end
            ST_DIV: begin
                we    = div_done;
                wdata = div_q;
            end
            ST_IN: begin
                we    = cin_valid;
                waddr = fc;
                wdata = cin_eof ? '1 : W'(cin_data);
            end
            default: we = 1'b0;
        endcase
    end

    // Array-port request fields for fetch and array operations.
    always_comb begin
        am_req_valid = (st == ST_FETCH) || (st == ST_ARRAY);
        req_op       = AM_FETCH;
        am_req_id    = '0;
        am_req_off   = pc;
        am_req_data  = '0;
        if (st == ST_ARRAY) begin
            case (op)
                OP_RD:    begin req_op = AM_READ;  am_req_id = vb; am_req_off = vc; end
                OP_WR:    begin req_op = AM_WRITE; am_req_id = va; am_req_off = vb;
                                am_req_data = vc; end
                OP_NEW:   begin req_op = AM_ALLOC; am_req_off = vc; end
                OP_DROP:  begin req_op = AM_FREE;  am_req_id = vc; am_req_off = '0; end
                default:  begin req_op = AM_LOADP; am_req_id = vb; am_req_off = vc; end
            endcase
        end
    end
    assign am_req_op = req_op;

    // Sequencer: fetch, decode/execute and the wait states.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_FETCH;
            pc <= '0;
            ir <= '0;
        end else begin
            case (st)
                ST_FETCH: if (am_ack) begin
                    if (am_ack_fault) st <= ST_FAULT;
                    else begin
                        ir <= am_ack_data;
                        pc <= pc + 1'b1;
                        st <= ST_EXEC;
                    end
                end
                ST_EXEC: begin
                    case (op)
                        OP_CMOV, OP_ADD, OP_MUL, OP_NAND, OP_IMM: st <= ST_FETCH;
                        OP_DIV:  st <= (vc == '0) ? ST_FAULT : ST_DIV;
                        OP_HALT: st <= ST_HALT;
                        OP_RD, OP_WR, OP_NEW, OP_DROP, OP_LOADP: st <= ST_ARRAY;
                        OP_OUT:  st <= (vc > W'(255)) ? ST_FAULT : ST_OUT;
                        OP_IN:   st <= ST_IN;
                        default: st <= ST_FAULT;
                    endcase
                end
                ST_ARRAY: if (am_ack) begin
                    if (am_ack_fault) st <= ST_FAULT;
                    else begin
                        if (op == OP_LOADP) pc <= vc;
                        st <= ST_FETCH;
                    end
                end
                ST_DIV:  if (div_done)   st <= ST_FETCH;
                ST_OUT:  if (cout_ready) st <= ST_FETCH;
                ST_IN:   if (cin_valid)  st <= ST_FETCH;
                default: st <= st;
            endcase
        end
    end

    assign cout_valid = (st == ST_OUT);
    assign cout_data  = vc[BYTE_W-1:0];
    assign cin_ready  = (st == ST_IN);
    assign halted     = (st == ST_HALT);
    assign fault      = (st == ST_FAULT);

    // R3: a successful fetch moves the counter forward by exactly one.
    a_r3_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FETCH && am_ack && !am_ack_fault) |=> pc == $past(pc) + 1'b1);
    // R13: an unacknowledged request holds all its fields.
    a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (am_req_valid && !am_ack) |=> am_req_valid && $stable(am_req_op)
            && $stable(am_req_id) && $stable(am_req_off) && $stable(am_req_data));
    // R9: an offered output byte stays until taken.
    a_r9_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cout_valid && !cout_ready) |=> cout_valid && $stable(cout_data));
    // R11: halt is sticky.
    a_r11_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);
    // R12: fault is sticky.
    a_r12_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault);
    // R11: a stopped core is silent on every port.
    a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (halted || fault) |-> !am_req_valid && !cout_valid && !cin_ready);
    // R6: the core waits in the divide state only while the divider works.
    a_r6_div_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DIV) |-> (div_busy || div_done));
endmodule

// File: tb/sim_wmc_core.sv
`timescale 1ns/1ps
module sim_wmc_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        am_req_valid, am_ack = 1'b0, am_ack_fault = 1'b0;
    logic [2:0]  am_req_op;
    logic [31:0] am_req_id, am_req_off, am_req_data, am_ack_data = '0;
    logic        cout_valid, cout_ready = 1'b0;
    logic [7:0]  cout_data, cin_data = '0;
    logic        cin_valid = 1'b0, cin_eof = 1'b0, cin_ready, halted, fault;

    always #5 clk = ~clk;

    wmc_core u0 (.*);

    int n_chk = 0, n_fail = 0;
    logic [31:0] prog [0:63];
    logic [31:0] darr [0:15];
    logic [31:0] wlog [0:63];
    logic [31:0] flog [0:15];
    logic [7:0]  olog [0:7];
    logic [7:0]  ibytes [0:3];
    logic        ieof [0:3];
    int wn, fn, on, req_n, in_idx, in_wait, out_wait, pp;
    logic [31:0] alloc_sz, freed_id, last_wid;
    logic        inj_fault = 1'b0, pend = 1'b0;
    logic [2:0]  s_op;
    logic [31:0] s_id, s_off, s_data;
    logic        rs_halt, rs_fault, rs_valid;
    logic [2:0]  rs_op;
    logic [31:0] rs_off;

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(input int o, input int a, input int b, input int c);
        return {4'(o), 19'd0, 3'(a), 3'(b), 3'(c)};
    endfunction
    function automatic logic [31:0] ldi(input int a, input logic [24:0] v);
        return {4'd13, 3'(a), v};
    endfunction

    task automatic em(input logic [31:0] w);
        prog[pp] = w;
        pp++;
    endtask

    task automatic clear_all();
        for (int i = 0; i < 64; i++) prog[i] = 32'h7000_0000;
        for (int i = 0; i < 16; i++) darr[i] = 32'h7000_0000;
        wn = 0; fn = 0; on = 0; req_n = 0; in_idx = 0; in_wait = 0; out_wait = 0; pp = 0;
        inj_fault = 1'b0;
    endtask

    task automatic run_prog(input int maxc);
        int cyc;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rs_halt = halted; rs_fault = fault; rs_valid = am_req_valid;
        rs_op = am_req_op; rs_off = am_req_off;
        rst_n = 1'b1;
        cyc = 0;
        while (!(halted || fault) && cyc < maxc) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    // Array manager model: two-cycle latency, checks request stability (R13).
    always @(negedge clk) begin
        if (!rst_n) begin
            am_ack = 1'b0; am_ack_fault = 1'b0; pend = 1'b0;
        end else if (am_ack) begin
            am_ack = 1'b0; am_ack_fault = 1'b0;
        end else if (am_req_valid && !pend) begin
            pend = 1'b1;
            s_op = am_req_op; s_id = am_req_id; s_off = am_req_off; s_data = am_req_data;
        end else if (am_req_valid && pend) begin
            pend = 1'b0;
            chk(s_op == am_req_op && s_id == am_req_id && s_off == am_req_off
                && s_data == am_req_data, "R13 request held", am_req_off, s_off);
            am_ack = 1'b1; am_ack_data = '0; req_n++;
            case (am_req_op)
                3'd0: begin
                    am_ack_data = prog[am_req_off[5:0]];
                    if (fn < 16) flog[fn] = am_req_off;
                    fn++;
                end
                3'd1: if (inj_fault) am_ack_fault = 1'b1;
                      else am_ack_data = darr[am_req_off[3:0]];
                3'd2: begin
                    darr[am_req_off[3:0]] = am_req_data;
                    last_wid = am_req_id;
                    if (wn < 64) wlog[wn] = am_req_data;
                    wn++;
                end
                3'd3: begin alloc_sz = am_req_off; am_ack_data = 32'h77; end
                3'd4: freed_id = am_req_id;
                default: for (int i = 0; i < 16; i++) prog[i] = darr[i];
            endcase
        end
    end

    // Console input source with a three-cycle delay per byte.
    always @(negedge clk) begin
        if (!rst_n) cin_valid = 1'b0;
        else if (cin_valid) cin_valid = 1'b0;
        else if (cin_ready) begin
            in_wait++;
            if (in_wait >= 3 && in_idx < 4) begin
                cin_valid = 1'b1; cin_data = ibytes[in_idx]; cin_eof = ieof[in_idx];
                in_idx++; in_wait = 0;
            end
        end
    end

    // Console output sink with a three-cycle delay per byte.
    always @(negedge clk) begin
        if (!rst_n) cout_ready = 1'b0;
        else if (cout_ready) cout_ready = 1'b0;
        else if (cout_valid) begin
            out_wait++;
            if (out_wait >= 3) begin
                cout_ready = 1'b1;
                if (on < 8) olog[on] = cout_data;
                on++; out_wait = 0;
            end
        end
    end

    // Watchdog.
    initial begin
        #(200000 * 10);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    logic [24:0] vh [0:5];
    logic [6:0]  vl [0:5];

    initial begin
        vh[0] = 0; vh[1] = 0; vh[2] = 1; vh[3] = 25'h1FF_FFFF; vh[4] = 25'h100_0000; vh[5] = 25'd12345;
        vl[0] = 0; vl[1] = 1; vl[2] = 0; vl[3] = 7'd127;       vl[4] = 0;            vl[5] = 7'd67;

        // R2: every register index via opcode 13, then dumped by writes.
        clear_all();
        for (int k = 0; k < 8; k++) em(ldi(k, 25'(32'h100 + k * 32'h11)));
        for (int k = 0; k < 8; k++) em(enc(2, 0, 0, k));
        em(ldi(3, 25'h1FF_FFFF));
        em(enc(2, 0, 0, 3));
        em(enc(7, 0, 0, 0));
        run_prog(2000);
        for (int k = 0; k < 8; k++)
            chk(wlog[k] == 32'h100 + k * 32'h11, "R2 register field", wlog[k], 32'h100 + k * 32'h11);
        chk(wlog[8] == 32'h01FF_FFFF, "R2 immediate zero-extend", wlog[8], 32'h01FF_FFFF);
        chk(halted == 1'b1 && wn == 9, "R11 halt after sweep", 32'(wn), 32'd9);

        // R1 and R3: registers cleared by reset, fetch offsets consecutive.
        clear_all();
        for (int k = 0; k < 8; k++) em(enc(2, 0, 0, k));
        em(enc(7, 0, 0, 0));
        run_prog(2000);
        chk(rs_halt == 1'b0 && rs_fault == 1'b0, "R1 stop flags low in reset", {rs_halt, rs_fault}, 0);
        chk(rs_valid && rs_op == 3'd0 && rs_off == 0, "R1 first fetch at 0", rs_off, 0);
        for (int k = 0; k < 8; k++) chk(wlog[k] == 0, "R1 register zero", wlog[k], 0);
        for (int k = 0; k < 9; k++) chk(flog[k] == k, "R3 fetch offset", flog[k], k);

        // R4, R5, R6: arithmetic sweep over pairs of 32-bit operands.
        for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 6; j++) begin
                logic [31:0] x, y, e;
                x = {vh[i], 7'd0} + 32'(vl[i]);
                y = {vh[j], 7'd0} + 32'(vl[j]);
                clear_all();
                em(ldi(5, 25'd128));
                em(ldi(1, vh[i])); em(enc(4, 1, 1, 5)); em(ldi(2, 25'(vl[i]))); em(enc(3, 1, 1, 2));
                em(ldi(2, vh[j])); em(enc(4, 2, 2, 5)); em(ldi(3, 25'(vl[j]))); em(enc(3, 2, 2, 3));
                em(enc(3, 3, 1, 2)); em(enc(2, 0, 0, 3));
                em(enc(4, 3, 1, 2)); em(enc(2, 0, 0, 3));
                em(enc(6, 3, 1, 2)); em(enc(2, 0, 0, 3));
                em(ldi(3, 25'h5A)); em(enc(0, 3, 1, 2)); em(enc(2, 0, 0, 3));
                if (y != 0) begin em(enc(5, 3, 1, 2)); em(enc(2, 0, 0, 3)); end
                em(enc(7, 0, 0, 0));
                run_prog(3000);
                chk(wlog[0] == x + y, "R5 add", wlog[0], x + y);
                chk(wlog[1] == x * y, "R5 multiply", wlog[1], x * y);
                chk(wlog[2] == ~(x & y), "R5 nand", wlog[2], ~(x & y));
                e = (y != 0) ? x : 32'h5A;
                chk(wlog[3] == e, "R4 conditional move", wlog[3], e);
                if (y != 0) chk(wlog[4] == x / y, "R6 divide", wlog[4], x / y);
                chk(halted && !fault, "R6 no fault on sweep", {halted, fault}, 2);
            end
        end

        // R6: divide by zero faults with no write afterwards.
        clear_all();
        em(ldi(1, 25'd7)); em(enc(5, 3, 1, 2)); em(enc(2, 0, 0, 3)); em(enc(7, 0, 0, 0));
        run_prog(2000);
        chk(fault && !halted && wn == 0, "R6 divide by zero faults", {halted, fault}, 1);

        // R12: opcodes 14 and 15 fault and stop requesting.
        for (int o = 14; o < 16; o++) begin
            int rq;
            clear_all();
            em(ldi(1, 25'd1)); em({4'(o), 28'd0}); em(enc(2, 0, 0, 1)); em(enc(7, 0, 0, 0));
            run_prog(2000);
            rq = req_n;
            repeat (20) @(negedge clk);
            chk(fault && wn == 0 && req_n == rq, "R12 undefined opcode faults", 32'(req_n), 32'(rq));
        end

        // R11: halt as the first word stops all requests.
        clear_all();
        em(enc(7, 0, 0, 0)); em(enc(2, 0, 0, 0));
        run_prog(2000);
        repeat (20) @(negedge clk);
        chk(halted && !fault && req_n == 1 && wn == 0, "R11 halt is final", 32'(req_n), 1);

        // R7: read, create, release and write through the array port.
        clear_all();
        darr[3] = 32'hCAFE_F00D;
        em(ldi(6, 25'd3)); em(enc(1, 1, 7, 6)); em(enc(2, 0, 0, 1));
        em(ldi(3, 25'd9)); em(enc(8, 0, 4, 3)); em(enc(2, 0, 0, 4));
        em(enc(9, 0, 0, 4));
        em(ldi(2, 25'hABC)); em(enc(2, 4, 6, 2));
        em(enc(7, 0, 0, 0));
        run_prog(2000);
        chk(wlog[0] == 32'hCAFE_F00D, "R7 read into A", wlog[0], 32'hCAFE_F00D);
        chk(alloc_sz == 9, "R7 create size from C", alloc_sz, 9);
        chk(wlog[1] == 32'h77, "R7 new id into B", wlog[1], 32'h77);
        chk(freed_id == 32'h77, "R7 release id from C", freed_id, 32'h77);
        chk(darr[3] == 32'hABC && last_wid == 32'h77, "R7 write id/offset/data", darr[3], 32'hABC);

        // R7: program-load replaces the program and resumes at offset C.
        clear_all();
        darr[1] = ldi(1, 25'h55);
        darr[2] = enc(2, 0, 0, 1);
        em(ldi(2, 25'd1)); em(ldi(7, 25'd5)); em(enc(12, 0, 7, 2)); em(enc(7, 0, 0, 0));
        run_prog(2000);
        chk(halted && wn == 1 && wlog[0] == 32'h55, "R7 load program runs new code", wlog[0], 32'h55);
        chk(flog[3] == 1, "R7 resume offset from C", flog[3], 1);

        // R8: a faulted acknowledge stops the core with no result.
        clear_all();
        inj_fault = 1'b1;
        em(enc(1, 1, 0, 0)); em(enc(2, 0, 0, 1)); em(enc(7, 0, 0, 0));
        run_prog(2000);
        chk(fault && wn == 0, "R8 manager fault", 32'(wn), 0);

        // R9: bytes 0x41 and 0xFF are emitted, 256 faults.
        clear_all();
        em(ldi(1, 25'h41)); em(enc(10, 0, 0, 1)); em(ldi(1, 25'hFF)); em(enc(10, 0, 0, 1));
        em(enc(7, 0, 0, 0));
        run_prog(2000);
        chk(on == 2 && olog[0] == 8'h41 && olog[1] == 8'hFF, "R9 output bytes",
            {olog[0], olog[1]}, 16'h41FF);
        clear_all();
        em(ldi(1, 25'h100)); em(enc(10, 0, 0, 1)); em(enc(7, 0, 0, 0));
        run_prog(2000);
        chk(fault && on == 0, "R9 output above 255 faults", 32'(on), 0);

        // R10: input byte then end-of-input.
        clear_all();
        ibytes[0] = 8'h9C; ieof[0] = 1'b0; ibytes[1] = 8'h00; ieof[1] = 1'b1;
        em(enc(11, 0, 0, 1)); em(enc(2, 0, 0, 1)); em(enc(11, 0, 0, 2)); em(enc(2, 0, 0, 2));
        em(enc(7, 0, 0, 0));
        run_prog(2000);
        chk(wlog[0] == 32'h9C, "R10 input zero-extended", wlog[0], 32'h9C);
        chk(wlog[1] == 32'hFFFF_FFFF, "R10 end-of-input all ones", wlog[1], 32'hFFFF_FFFF);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule